// File: doc/BRIEF.md
# Interrupt Coalescing Controller

This block turns streams of descriptor completion events into a reduced number of interrupt requests. Each receive ring reports a descriptor it has filled, and each transmit ring reports a descriptor it has retired. Every such source owns one interrupt vector. For each vector the block counts the events pending since that vector's last interrupt. It raises the interrupt when the pending count reaches a host-programmed threshold. It also raises it when a host-programmed holdoff time has passed since the previous interrupt and at least one event is still waiting.

The host sets a threshold and a holdoff value for every vector through a small register write port. It can read any value back through a registered read port. After a vector fires, it stays quiet until the host acknowledges it. Events that arrive in the meantime are still counted, so no completion is lost. The vectors work independently of one another, and several of them may fire in the same cycle.

Top module: `coal_irq_ctrl`

## Requirements
- R1: A vector with no interrupt outstanding pulses `irq_o` one clock after its pending event count has become greater than or equal to its threshold and non-zero.
- R2: A vector with at least one pending event also pulses once its timer, which counts clock cycles since its last pulse (or since reset), reaches its holdoff value, even if the count is below threshold.
- R3: A vector with zero pending events never pulses, whatever its timer value. The timer keeps running and saturates, and the next event then triggers the pulse.
- R4: On the clock edge that raises a pulse, the vector's count is cleared and its timer restarts from zero. An event arriving on that same edge is counted as the first event of the new interval.
- R5: A threshold of 0 or 1, or a holdoff of 0, makes every pending event interrupt at the earliest allowed cycle.
- R6: Each pulse is exactly one cycle wide. Vectors are independent, and several bits of `irq_o` may be high in the same cycle.
- R7: After a pulse, a vector does not pulse again until `irq_ack_i` for that vector has been high on some later clock edge. Events that arrive meanwhile keep being counted. An acknowledge for a vector with no outstanding pulse has no effect.
- R8: The pending count saturates at its all-ones value and does not wrap. For example, with a 4-bit count, 16 events that arrive while a pulse is unacknowledged still leave events pending.
- R9: Register address = {vector index, field bit}. Field bit 0 selects the count threshold (low CNT_W bits of the write data) and field bit 1 selects the holdoff (low TIME_W bits). A write takes effect on the next clock. `cfg_rdata_o` returns the addressed value, zero-extended, one clock after `cfg_raddr_i`, and shows the value from before any write on that same edge. Addresses above the last vector are ignored on write and read as zero.
- R10: Receive ring k drives vector k, and transmit ring k drives vector NUM_RING+k.
- R11: After synchronous reset, `irq_o` is all zero, no pulse is outstanding, all counts and timers are zero, and every threshold and holdoff reads back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_evt_i | input | NUM_RING | One bit per receive ring: a descriptor was filled this cycle |
| tx_evt_i | input | NUM_RING | One bit per transmit ring: a descriptor was retired this cycle |
| irq_ack_i | input | NUM_VEC | Host acknowledge, one bit per vector |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_waddr_i | input | ADDR_W | Write address {vector, field} |
| cfg_wdata_i | input | DATA_W | Write data |
| cfg_raddr_i | input | ADDR_W | Read address {vector, field} |
| cfg_rdata_o | output | DATA_W | Registered read data |
| irq_o | output | NUM_VEC | Interrupt pulse, one bit per vector |

## Verification
The bench builds the block with two rings, which gives four vectors, a 4-bit event count and a 6-bit timer. With these sizes, count saturation takes only 16 unacknowledged events and timer saturation only 63 cycles, so both come within reach. Every address of the register map is a valid vector, and transmit vectors sit apart from receive vectors. A bench model steps alongside the design and checks each interrupt bit and the read data on every cycle. Directed sequences target each threshold, holdoff, acknowledge and saturation case, and a long seeded random phase then mixes events, acknowledges and reprogramming.

// File: rtl/coal_pkg.sv
package coal_pkg;

  // Field selected by the low address bit.
  typedef enum logic {
    FLD_THRESH = 1'b0,
    FLD_HOLD   = 1'b1
  } coal_field_e;

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/coal_cfg_regs.sv
module coal_cfg_regs #(
  parameter int NUM_VEC = 8,
  parameter int CNT_W   = 8,
  parameter int TIME_W  = 16,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                we_i,
  input  logic [ADDR_W-1:0]                   waddr_i,
  input  logic [DATA_W-1:0]                   wdata_i,
  input  logic [ADDR_W-1:0]                   raddr_i,
  output logic [DATA_W-1:0]                   rdata_o,
  output logic [NUM_VEC-1:0][CNT_W-1:0]       thr_o,
  output logic [NUM_VEC-1:0][TIME_W-1:0]      hold_o
);
  import coal_pkg::*;

  localparam int VEC_W = ADDR_W - 1;

  logic [VEC_W-1:0] wr_vec, rd_vec;
  coal_field_e      wr_fld, rd_fld;
  logic             rd_valid;

  assign wr_vec   = waddr_i[ADDR_W-1:1];
  assign wr_fld   = coal_field_e'(waddr_i[0]);
  assign rd_vec   = raddr_i[ADDR_W-1:1];
  assign rd_fld   = coal_field_e'(raddr_i[0]);
  assign rd_valid = (32'(rd_vec) < NUM_VEC);

  // One threshold and one holdoff register per vector.
  for (genvar g = 0; g < NUM_VEC; g++) begin : g_reg
    logic hit;
    assign hit = we_i && (32'(wr_vec) == g);

    always_ff @(posedge clk) begin
      if (rst) begin
        thr_o[g]  <= '0;
        hold_o[g] <= '0;
      end else if (hit) begin
        if (wr_fld == FLD_THRESH) thr_o[g]  <= wdata_i[CNT_W-1:0];
        else                      hold_o[g] <= wdata_i[TIME_W-1:0];
      end
    end
  end

  // Registered read-back, showing pre-write contents.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else if (!rd_valid) begin
      rdata_o <= '0;
    end else if (rd_fld == FLD_THRESH) begin
      rdata_o <= DATA_W'(thr_o[rd_vec]);
    end else begin
      rdata_o <= DATA_W'(hold_o[rd_vec]);
    end
  end

endmodule

// File: rtl/coal_vec.sv
module coal_vec #(
  parameter int CNT_W  = 8,
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_i,
  input  logic              ack_i,
  input  logic [CNT_W-1:0]  thr_i,
  input  logic [TIME_W-1:0] hold_i,
  output logic              irq_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              infl_o
);

  localparam logic [CNT_W-1:0]  CNT_MAX = '1;
  localparam logic [TIME_W-1:0] TMR_MAX = '1;

  logic [CNT_W-1:0]  cnt_q;
  logic [TIME_W-1:0] tmr_q;
  logic              infl_q;
  logic              pending, count_hit, time_hit, fire;

  // A threshold of 0 or 1 is met by any pending event; a holdoff of 0
  // is met by any timer value, so both collapse to per-event interrupts.
  assign pending   = (cnt_q != '0);
  assign count_hit = (cnt_q >= thr_i);
  assign time_hit  = (tmr_q >= hold_i);
  assign fire      = !infl_q && pending && (count_hit || time_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tmr_q  <= '0;
      infl_q <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      irq_o <= fire;
      if (fire) begin
        cnt_q  <= {{(CNT_W-1){1'b0}}, evt_i};
        tmr_q  <= '0;
        infl_q <= 1'b1;
      end else begin
        if (evt_i && (cnt_q != CNT_MAX)) cnt_q <= cnt_q + 1'b1;
        if (tmr_q != TMR_MAX)            tmr_q <= tmr_q + 1'b1;
        if (ack_i)                       infl_q <= 1'b0;
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign infl_o = infl_q;

endmodule

// File: rtl/coal_irq_ctrl.sv
module coal_irq_ctrl #(
  parameter int  NUM_RING = 4,
  parameter int  CNT_W    = 8,
  parameter int  TIME_W   = 16,
  localparam int NUM_VEC  = 2 * NUM_RING,
  localparam int VEC_W    = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
  localparam int ADDR_W   = VEC_W + 1,
  localparam int DATA_W   = (CNT_W > TIME_W) ? CNT_W : TIME_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_RING-1:0] rx_evt_i,
  input  logic [NUM_RING-1:0] tx_evt_i,
  input  logic [NUM_VEC-1:0]  irq_ack_i,
  input  logic                cfg_we_i,
  input  logic [ADDR_W-1:0]   cfg_waddr_i,
  input  logic [DATA_W-1:0]   cfg_wdata_i,
  input  logic [ADDR_W-1:0]   cfg_raddr_i,
  output logic [DATA_W-1:0]   cfg_rdata_o,
  output logic [NUM_VEC-1:0]  irq_o
);

  logic [NUM_VEC-1:0]             vec_evt;
  logic [NUM_VEC-1:0][CNT_W-1:0]  vec_thr;
  logic [NUM_VEC-1:0][TIME_W-1:0] vec_hold;
  logic [NUM_VEC-1:0][CNT_W-1:0]  vec_cnt;
  logic [NUM_VEC-1:0]             vec_infl;

  // Receive rings occupy the low vectors, transmit rings the high ones.
  assign vec_evt = {tx_evt_i, rx_evt_i};

  coal_cfg_regs #(
    .NUM_VEC (NUM_VEC),
    .CNT_W   (CNT_W),
    .TIME_W  (TIME_W),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
  ) cfg_i (
    .clk     (clk),
    .rst     (rst),
    .we_i    (cfg_we_i),
    .waddr_i (cfg_waddr_i),
    .wdata_i (cfg_wdata_i),
    .raddr_i (cfg_raddr_i),
    .rdata_o (cfg_rdata_o),
    .thr_o   (vec_thr),
    .hold_o  (vec_hold)
  );

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_vec
    coal_vec #(
      .CNT_W  (CNT_W),
      .TIME_W (TIME_W)
    ) vec_i (
      .clk    (clk),
      .rst    (rst),
      .evt_i  (vec_evt[g]),
      .ack_i  (irq_ack_i[g]),
      .thr_i  (vec_thr[g]),
      .hold_i (vec_hold[g]),
      .irq_o  (irq_o[g]),
      .cnt_o  (vec_cnt[g]),
      .infl_o (vec_infl[g])
    );
  end

endmodule

// File: rtl/coal_irq_ctrl_chk.sv
module coal_irq_ctrl_chk #(
  parameter int NUM_VEC = 8,
  parameter int CNT_W   = 8
) (
  input logic                          clk,
  input logic                          rst,
  input logic [NUM_VEC-1:0]            irq,
  input logic [NUM_VEC-1:0][CNT_W-1:0] cnt_all,
  input logic [NUM_VEC-1:0]            infl_all
);

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_chk
    AST_PENDING_BEFORE_PULSE: assert property (@(posedge clk) disable iff (rst)
      irq[v] |-> ($past(cnt_all[v]) != '0)); // R3
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
      irq[v] |=> !irq[v]); // R6
    AST_CLEAR_ON_FIRE: assert property (@(posedge clk) disable iff (rst)
      irq[v] |-> (cnt_all[v] <= CNT_W'(1))); // R4
    AST_ACK_GATE: assert property (@(posedge clk) disable iff (rst)
      irq[v] |-> !$past(infl_all[v])); // R7
    AST_OUTSTANDING_SET: assert property (@(posedge clk) disable iff (rst)
      irq[v] |-> infl_all[v]); // R7
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
      (cnt_all[v] < $past(cnt_all[v])) |-> irq[v]); // R8
  end

endmodule

bind coal_irq_ctrl coal_irq_ctrl_chk #(
  .NUM_VEC (NUM_VEC),
  .CNT_W   (CNT_W)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .irq      (irq_o),
  .cnt_all  (vec_cnt),
  .infl_all (vec_infl)
);

// File: tb/coal_irq_ctrl_tb_top.sv
module coal_irq_ctrl_tb_top;

  localparam int NR   = 2;
  localparam int NV   = 2 * NR;
  localparam int CW   = 4;
  localparam int TW   = 6;
  localparam int AW   = 3;
  localparam int DW   = 6;
  localparam int CMAX = (1 << CW) - 1;
  localparam int TMAX = (1 << TW) - 1;

  logic          clk = 1'b0;
  logic          rst;
  logic [NR-1:0] rx_evt, tx_evt;
  logic [NV-1:0] ack;
  logic          we;
  logic [AW-1:0] waddr, raddr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic [NV-1:0] irq;

  always #10 clk = ~clk;

  coal_irq_ctrl #(.NUM_RING(NR), .CNT_W(CW), .TIME_W(TW)) dut_i (
    .clk(clk), .rst(rst), .rx_evt_i(rx_evt), .tx_evt_i(tx_evt),
    .irq_ack_i(ack), .cfg_we_i(we), .cfg_waddr_i(waddr), .cfg_wdata_i(wdata),
    .cfg_raddr_i(raddr), .cfg_rdata_o(rdata), .irq_o(irq)
  );

  // Reference state built from the requirements.
  int        m_cnt [NV];
  int        m_tmr [NV];
  bit        m_infl[NV];
  int        m_thr [NV];
  int        m_hold[NV];
  bit [NV-1:0] m_irq;
  int        m_rd;
  string     req;
  int        n_cmp = 0;
  int        n_bad = 0;
  bit        done  = 1'b0;

  task automatic check(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int v = 0; v < NV; v++) begin
      m_cnt[v] = 0; m_tmr[v] = 0; m_infl[v] = 0; m_thr[v] = 0; m_hold[v] = 0;
    end
    m_irq = '0;
    m_rd  = 0;
  endtask

  // Predicts the state after the next rising edge from the driven inputs.
  task automatic model_step();
    int  vsel;
    bit  e, fire;
    for (int v = 0; v < NV; v++) begin
      e    = (v < NR) ? rx_evt[v] : tx_evt[v-NR];   // R10 mapping
      fire = !m_infl[v] && (m_cnt[v] != 0) &&
             ((m_cnt[v] >= m_thr[v]) || (m_tmr[v] >= m_hold[v]));
      m_irq[v] = fire;
      if (fire) begin
        m_cnt[v] = e; m_tmr[v] = 0; m_infl[v] = 1;
      end else begin
        if (e && m_cnt[v] < CMAX) m_cnt[v]++;
        if (m_tmr[v] < TMAX)      m_tmr[v]++;
        if (ack[v])               m_infl[v] = 0;
      end
    end
    vsel = int'(raddr) >> 1;
    if (vsel < NV) m_rd = raddr[0] ? m_hold[vsel] : m_thr[vsel];
    else           m_rd = 0;
    vsel = int'(waddr) >> 1;
    if (we && vsel < NV) begin
      if (waddr[0]) m_hold[vsel] = int'(wdata) & TMAX;
      else          m_thr[vsel]  = int'(wdata) & CMAX;
    end
  endtask

  task automatic compare();
    check("irq_o", int'(irq), int'(m_irq));
    check("cfg_rdata_o", int'(rdata), m_rd);
  endtask

  task automatic step(input logic [NR-1:0] rx, input logic [NR-1:0] tx,
                      input logic [NV-1:0] ak, input logic w, input int wa,
                      input int wd, input int ra);
    rx_evt = rx; tx_evt = tx; ack = ak; we = w;
    waddr = AW'(wa); wdata = DW'(wd); raddr = AW'(ra);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n, input logic [NV-1:0] ak);
    for (int i = 0; i < n; i++) step('0, '0, ak, 1'b0, 0, 0, 0);
  endtask

  task automatic wr(input int vec, input int fld, input int val);
    step('0, '0, '1, 1'b1, vec * 2 + fld, val, vec * 2 + fld);
  endtask

  initial begin
    rst = 1'b1; rx_evt = '0; tx_evt = '0; ack = '0; we = 1'b0;
    waddr = '0; wdata = '0; raddr = '0;
    model_reset();
    repeat (4) @(negedge clk);
    rst = 1'b0;

    req = "R11";
    step('0, '0, '0, 1'b0, 0, 0, 0);
    check("irq after reset", int'(irq), 0);
    for (int a = 0; a < 2 * NV; a++) step('0, '0, '0, 1'b0, 0, 0, a);
    idle(1, '0);

    req = "R9";
    wr(2, 0, 5);
    wr(2, 1, 7);
    step('0, '0, '0, 1'b0, 0, 0, 4);
    step('0, '0, '0, 1'b0, 0, 0, 5);
    check("holdoff readback", int'(rdata), 7);
    step('0, '0, '0, 1'b1, 4, 9, 4);   // same-edge write: old value read
    step('0, '0, '0, 1'b0, 0, 0, 4);

    req = "R10";
    step('0, 2'b10, '0, 1'b0, 0, 0, 0);
    idle(1, '0);
    check("tx ring 1 on vector 3", int'(irq), 8);
    idle(2, '1);

    req = "R5";
    for (int i = 0; i < 6; i++) step(i[0] ? 2'b01 : 2'b00, '0, '1, 1'b0, 0, 0, 0);
    idle(3, '1);

    req = "R1";
    wr(1, 0, 4); wr(1, 1, 63);
    for (int i = 0; i < 4; i++) step(2'b10, '0, '1, 1'b0, 0, 0, 0);
    idle(3, '1);

    req = "R4";
    wr(1, 0, 2);
    for (int i = 0; i < 8; i++) step(2'b10, '0, '1, 1'b0, 0, 0, 0);
    idle(3, '1);

    req = "R2";
    wr(0, 0, 15); wr(0, 1, 10);
    step(2'b01, '0, '1, 1'b0, 0, 0, 0);
    idle(15, '1);

    req = "R3";
    wr(2, 0, 15); wr(2, 1, 3);
    idle(12, '1);
    step('0, '0, '1, 1'b0, 0, 0, 0);
    step(2'b00, '0, '1, 1'b0, 0, 0, 0);
    rx_evt = '0;
    wr(2, 0, 15);
    step('0, '0, '1, 1'b0, 0, 0, 0);
    idle(8, '1);

    req = "R6";
    wr(0, 0, 0); wr(0, 1, 0);
    step(2'b01, 2'b10, '1, 1'b0, 0, 0, 0);
    idle(1, '1);
    check("two vectors together", int'(irq), 9);
    idle(3, '1);

    req = "R7";
    step('0, 2'b10, '0, 1'b0, 0, 0, 0);
    idle(2, '0);
    for (int i = 0; i < 3; i++) step('0, 2'b10, '0, 1'b0, 0, 0, 0);
    idle(5, '0);
    step('0, '0, 4'b0111, 1'b0, 0, 0, 0);   // other vectors ack: no effect on 3
    idle(3, '0);
    step('0, '0, 4'b1000, 1'b0, 0, 0, 0);
    idle(4, '1);

    req = "R8";
    wr(3, 0, 15); wr(3, 1, 63);
    step('0, 2'b10, '0, 1'b0, 0, 0, 0);      // one event, threshold unmet
    wr(3, 0, 1);
    idle(3, '0);                              // fires, stays unacknowledged
    for (int i = 0; i < 16; i++) step('0, 2'b10, '0, 1'b0, 0, 0, 0);
    step('0, '0, 4'b1000, 1'b0, 0, 0, 0);
    idle(1, '0);
    check("saturated count still pending", int'(irq[3]), 1);
    idle(3, '1);

    req = "R1 random";
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4000; i++) begin
      logic [NR-1:0] r, t;
      logic [NV-1:0] a;
      logic          w;
      int            wa, wd;
      r  = NR'($urandom_range(0, 3) == 0 ? $urandom : 0);
      t  = NR'($urandom_range(0, 3) == 0 ? $urandom : 0);
      a  = NV'($urandom_range(0, 4) == 0 ? $urandom : 0);
      w  = ($urandom_range(0, 19) == 0);
      wa = $urandom_range(0, 2 * NV - 1);
      wd = wa[0] ? $urandom_range(0, 24) : $urandom_range(0, 9);
      step(r, t, a, w, wa, wd, $urandom_range(0, 2 * NV - 1));
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule